// File: doc/BRIEF.md
# Event Packet Data Generator

This block produces packets of 32-bit words that stand in for detector data, so that the capture, buffering and transfer path behind it can be tested without a live front end. Every packet has a fixed event-record layout: a ten-word header with constant marker values, the run number, an event counter and a spill counter. A payload of counting words follows, and a four-word trailer reports the payload length. The first word of a packet carries a start flag and the last word carries an end flag.

Software controls the block with a single 64-bit control word. One field sets the payload size in words, one sets the run number, and one sets how many packets make up a spill. A nonzero write starts generation, and the block then sends packets back to back until a zero write stops it. Output uses a valid/ready handshake, so the consumer can stall the stream at any word and no data is lost. A stop takes effect only after the packet in flight is complete.

Top module: `evgen_top`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a nonzero control word is written.
- R2: Control word fields are: bits 15:0 payload size, bits 31:16 run number, bits 55:32 packets per spill. A nonzero write while idle starts generation. If the write is captured at clock edge N, `out_valid` is still low after edge N and goes high after edge N+1.
- R3: Packet word 0 has `out_sop`=1 and data 0. Words 1 to 9 are, in order: 0xEE1234EE, 0x00000009, 0x03000000, 0xABCDACBD, the run number (zero-extended), the event ID, the spill number, 0xB0B0B0B0, 0x0D0D0D0D. `out_sop` is 0 on every word except word 0.
- R4: Words 10 to 10+S-1, where S is the payload size, carry the counting values 0 to S-1. With S=0 there are no payload words.
- R5: The last four words of a packet are 0x00000001, S, 0x00000001, and then 0 with `out_eop`=1. A packet is S+14 words long.
- R6: The event ID increments by one per packet. It starts at 0 for the first packet after generation starts from idle.
- R7: The spill number starts at 0 and increments after each run of F packets, where F is the packets-per-spill value latched at the start of each packet. F=0 counts as 1.
- R8: While `out_valid`=1 and `out_ready`=0, the block holds `out_valid`, `out_data`, `out_sop` and `out_eop` unchanged on the next cycle.
- R9: A zero write during a packet lets that packet finish. After its end word is accepted, `out_valid` stays low. A zero write while idle has no effect.
- R10: While generation is running, the start word of the next packet is valid in the cycle after the end word is accepted. A nonzero write during a packet changes size, run number and packets per spill from the next packet on. Event and spill counting continue without a reset.
- R11: Starting again after a stop resets the event ID and the spill number to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 64 | Control word value (fields per R2) |
| out_ready | input | 1 | Consumer can accept a word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
The checker properties assume that `out_ready` is a plain level input, with no dependence on `out_valid` in the same cycle. They also assume that every packet the block sends is consumed word by word to its end, since the checker's word-position counter follows accepted words only. The stimulus drives `out_ready` at the falling edge from a fixed stall pattern (always ready, every second cycle, or every third cycle), and it never drops a packet. Control writes are placed at chosen accepted-word positions inside a packet, or while the block is idle, so stop and reconfiguration requests never coincide with the acceptance of an end word.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
   localparam int HDR_WORDS = 10;
   localparam int TRL_WORDS = 4;
   localparam int FIXED_WORDS = HDR_WORDS + TRL_WORDS;

   localparam logic [31:0] K_HDR_MARK  = 32'hEE12_34EE;
   localparam logic [31:0] K_HDR_SIZE  = 32'h0000_0009;
   localparam logic [31:0] K_FORMAT    = 32'h0300_0000;
   localparam logic [31:0] K_SOURCE    = 32'hABCD_ACBD;
   localparam logic [31:0] K_TRIG_TYPE = 32'hB0B0_B0B0;
   localparam logic [31:0] K_EVT_TYPE  = 32'h0D0D_0D0D;
   localparam logic [31:0] K_TRL_ONE   = 32'h0000_0001;

   typedef enum logic {GS_IDLE, GS_SEND} gen_state_e;
endpackage

// File: rtl/evgen_cfg.sv
module evgen_cfg #(
   parameter int CFG_W  = 64,
   parameter int SIZE_W = 16,
   parameter int RUN_W  = 16,
   parameter int FRAG_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              run_on,
   output logic [SIZE_W-1:0] cfg_size,
   output logic [RUN_W-1:0]  cfg_run,
   output logic [FRAG_W-1:0] cfg_frag
);
   localparam int RUN_LO  = SIZE_W;
   localparam int FRAG_LO = SIZE_W + RUN_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_on   <= 1'b0;
         cfg_size <= '0;
         cfg_run  <= '0;
         cfg_frag <= '0;
      end else if (cfg_we) begin
         if (cfg_wdata == '0) begin
            run_on <= 1'b0;
         end else begin
            run_on   <= 1'b1;
            cfg_size <= cfg_wdata[SIZE_W-1:0];
            cfg_run  <= cfg_wdata[RUN_LO +: RUN_W];
            cfg_frag <= cfg_wdata[FRAG_LO +: FRAG_W];
         end
      end
   end
endmodule

// File: rtl/evgen_seq.sv
module evgen_seq
   import evgen_pkg::*;
#(
   parameter int SIZE_W  = 16,
   parameter int RUN_W   = 16,
   parameter int FRAG_W  = 24,
   parameter int EVID_W  = 32,
   parameter int SPILL_W = 32,
   parameter int IDX_W   = SIZE_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_on,
   input  logic [SIZE_W-1:0]  cfg_size,
   input  logic [RUN_W-1:0]   cfg_run,
   input  logic [FRAG_W-1:0]  cfg_frag,
   input  logic               out_ready,
   output logic               active,
   output logic [IDX_W-1:0]   idx,
   output logic [SIZE_W-1:0]  p_size,
   output logic [RUN_W-1:0]   p_run,
   output logic [EVID_W-1:0]  ev_id,
   output logic [SPILL_W-1:0] spill
);
   gen_state_e        state;
   logic [FRAG_W-1:0] p_frag;
   logic [FRAG_W-1:0] frag_cnt;
   logic [FRAG_W:0]   frag_next;
   logic [FRAG_W:0]   frag_lim;
   logic [IDX_W-1:0]  last_idx;
   logic              fire;
   logic              last_word;
   logic              spill_done;

   assign active     = (state == GS_SEND);
   assign fire       = active && out_ready;
   assign last_idx   = {1'b0, p_size} + IDX_W'(FIXED_WORDS - 1);
   assign last_word  = (idx == last_idx);
   assign frag_next  = {1'b0, frag_cnt} + 1'b1;
   assign frag_lim   = (p_frag == '0) ? (FRAG_W+1)'(1) : {1'b0, p_frag};
   assign spill_done = (frag_next >= frag_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= GS_IDLE;
         idx      <= '0;
         p_size   <= '0;
         p_run    <= '0;
         p_frag   <= '0;
         ev_id    <= '0;
         spill    <= '0;
         frag_cnt <= '0;
      end else if (state == GS_IDLE) begin
         if (run_on) begin
            state    <= GS_SEND;
            idx      <= '0;
            p_size   <= cfg_size;
            p_run    <= cfg_run;
            p_frag   <= cfg_frag;
            ev_id    <= '0;
            spill    <= '0;
            frag_cnt <= '0;
         end
      end else if (fire) begin
         if (last_word) begin
            ev_id <= ev_id + 1'b1;
            if (spill_done) begin
               frag_cnt <= '0;
               spill    <= spill + 1'b1;
            end else begin
               frag_cnt <= frag_next[FRAG_W-1:0];
            end
            if (run_on) begin
               idx    <= '0;
               p_size <= cfg_size;
               p_run  <= cfg_run;
               p_frag <= cfg_frag;
            end else begin
               state <= GS_IDLE;
            end
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/evgen_words.sv
module evgen_words
   import evgen_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 16,
   parameter int RUN_W   = 16,
   parameter int EVID_W  = 32,
   parameter int SPILL_W = 32,
   parameter int IDX_W   = SIZE_W + 1
) (
   input  logic [IDX_W-1:0]   idx,
   input  logic [SIZE_W-1:0]  p_size,
   input  logic [RUN_W-1:0]   p_run,
   input  logic [EVID_W-1:0]  ev_id,
   input  logic [SPILL_W-1:0] spill,
   output logic [DATA_W-1:0]  word,
   output logic               sop,
   output logic               eop
);
   logic [DATA_W-1:0] ev_word;
   logic [DATA_W-1:0] spill_word;
   logic [IDX_W-1:0]  trl_base;
   logic [IDX_W-1:0]  trl_rel;
   logic [IDX_W-1:0]  pay_rel;

   generate
      if (EVID_W >= DATA_W) begin : g_ev_cut
         assign ev_word = ev_id[DATA_W-1:0];
      end else begin : g_ev_pad
         assign ev_word = {{(DATA_W-EVID_W){1'b0}}, ev_id};
      end
      if (SPILL_W >= DATA_W) begin : g_sp_cut
         assign spill_word = spill[DATA_W-1:0];
      end else begin : g_sp_pad
         assign spill_word = {{(DATA_W-SPILL_W){1'b0}}, spill};
      end
   endgenerate

   assign trl_base = {1'b0, p_size} + IDX_W'(HDR_WORDS);
   assign trl_rel  = idx - trl_base;
   assign pay_rel  = idx - IDX_W'(HDR_WORDS);

   always_comb begin
      word = '0;
      sop  = 1'b0;
      eop  = 1'b0;
      if (idx < IDX_W'(HDR_WORDS)) begin
         case (idx[3:0])
            4'd0:    sop  = 1'b1;
            4'd1:    word = DATA_W'(K_HDR_MARK);
            4'd2:    word = DATA_W'(K_HDR_SIZE);
            4'd3:    word = DATA_W'(K_FORMAT);
            4'd4:    word = DATA_W'(K_SOURCE);
            4'd5:    word = DATA_W'(p_run);
            4'd6:    word = ev_word;
            4'd7:    word = spill_word;
            4'd8:    word = DATA_W'(K_TRIG_TYPE);
            default: word = DATA_W'(K_EVT_TYPE);
         endcase
      end else if (idx < trl_base) begin
         word = DATA_W'(pay_rel);
      end else begin
         case (trl_rel)
            IDX_W'(0): word = DATA_W'(K_TRL_ONE);
            IDX_W'(1): word = DATA_W'(p_size);
            IDX_W'(2): word = DATA_W'(K_TRL_ONE);
            default:   eop  = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/evgen_top.sv
module evgen_top #(
   parameter int CFG_W   = 64,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 16,
   parameter int RUN_W   = 16,
   parameter int FRAG_W  = 24,
   parameter int EVID_W  = 32,
   parameter int SPILL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop
);
   localparam int IDX_W = SIZE_W + 1;

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("evgen_top: DATA_W must be at least 32");
      end
      if (SIZE_W + RUN_W + FRAG_W > CFG_W) begin : g_bad_fields
         $error("evgen_top: control fields exceed CFG_W");
      end
      if (SIZE_W < 4 || SIZE_W > DATA_W || RUN_W > DATA_W) begin : g_bad_size_w
         $error("evgen_top: SIZE_W or RUN_W out of range");
      end
   endgenerate

   logic               run_on;
   logic [SIZE_W-1:0]  cfg_size;
   logic [RUN_W-1:0]   cfg_run;
   logic [FRAG_W-1:0]  cfg_frag;
   logic               active;
   logic [IDX_W-1:0]   idx;
   logic [SIZE_W-1:0]  p_size;
   logic [RUN_W-1:0]   p_run;
   logic [EVID_W-1:0]  ev_id;
   logic [SPILL_W-1:0] spill;
   logic               w_sop;
   logic               w_eop;

   evgen_cfg #(
      .CFG_W(CFG_W), .SIZE_W(SIZE_W), .RUN_W(RUN_W), .FRAG_W(FRAG_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .run_on(run_on), .cfg_size(cfg_size), .cfg_run(cfg_run), .cfg_frag(cfg_frag)
   );

   evgen_seq #(
      .SIZE_W(SIZE_W), .RUN_W(RUN_W), .FRAG_W(FRAG_W),
      .EVID_W(EVID_W), .SPILL_W(SPILL_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .run_on(run_on),
      .cfg_size(cfg_size), .cfg_run(cfg_run), .cfg_frag(cfg_frag),
      .out_ready(out_ready), .active(active), .idx(idx),
      .p_size(p_size), .p_run(p_run), .ev_id(ev_id), .spill(spill)
   );

   evgen_words #(
      .DATA_W(DATA_W), .SIZE_W(SIZE_W), .RUN_W(RUN_W),
      .EVID_W(EVID_W), .SPILL_W(SPILL_W), .IDX_W(IDX_W)
   ) u_words (
      .idx(idx), .p_size(p_size), .p_run(p_run), .ev_id(ev_id), .spill(spill),
      .word(out_data), .sop(w_sop), .eop(w_eop)
   );

   assign out_valid = active;
   assign out_sop   = active && w_sop;
   assign out_eop   = active && w_eop;
endmodule

// File: rtl/evgen_chk.sv
module evgen_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sop,
   input logic              out_eop
);
   logic [31:0] pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (out_valid && out_ready) begin
         if (out_eop) pos <= '0;
         else         pos <= pos + 1'b1;
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

   p_sop_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sop == (pos == 32'd0)));

   p_sop_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sop |-> out_data == '0);

   p_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && pos == 32'd1 |-> out_data == DATA_W'(32'hEE12_34EE));

   p_hdr_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && pos == 32'd2 |-> out_data == DATA_W'(32'd9));

   p_eop_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eop |-> out_data == '0 && !out_sop);

   p_stop_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_eop && out_ready));

   p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_eop |=> out_valid);
endmodule

bind evgen_top evgen_chk #(.DATA_W(DATA_W)) u_evgen_chk (
   .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
   .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/test_evgen_top.sv
`timescale 1ns/1ps
module test_evgen_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic        out_ready = 1'b0;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_sop;
   logic        out_eop;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evgen_top i_evgen_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop)
   );

   function automatic logic [63:0] mkcfg(input int size, input int run, input int frag);
      return {8'h00, 24'(frag), 16'(run), 16'(size)};
   endfunction

   // {sop, eop, data} expected at word position k
   function automatic logic [33:0] exp_word(input int k, input int size, input int run,
                                            input int ev, input int sp);
      if (k == 0) return {2'b10, 32'h0};
      if (k == 1) return {2'b00, 32'hEE1234EE};
      if (k == 2) return {2'b00, 32'h9};
      if (k == 3) return {2'b00, 32'h03000000};
      if (k == 4) return {2'b00, 32'hABCDACBD};
      if (k == 5) return {2'b00, 32'(run)};
      if (k == 6) return {2'b00, 32'(ev)};
      if (k == 7) return {2'b00, 32'(sp)};
      if (k == 8) return {2'b00, 32'hB0B0B0B0};
      if (k == 9) return {2'b00, 32'h0D0D0D0D};
      if (k < 10 + size) return {2'b00, 32'(k - 10)};
      if (k == size + 10) return {2'b00, 32'h1};
      if (k == size + 11) return {2'b00, 32'(size)};
      if (k == size + 12) return {2'b00, 32'h1};
      return {2'b01, 32'h0};
   endfunction

   function automatic string tag_of(input int k, input int size);
      if (k == 6) return "R6";
      if (k == 7) return "R7";
      if (k < 10) return "R3";
      if (k < 10 + size) return "R4";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // start from idle; checks the start latency
   task automatic start_gen(input logic [63:0] v);
      @(negedge clk);
      out_ready = 1'b0;
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      check(out_valid == 1'b0, "R2", "valid one cycle after write", 64'(out_valid), 64'd0);
      @(negedge clk);
      check(out_valid == 1'b1, "R2", "valid two cycles after write", 64'(out_valid), 64'd1);
   endtask

   task automatic rx_pkt(input int size, input int run, input int ev, input int sp,
                         input int mode, input int wr_at, input logic [63:0] wr_val,
                         input bit need_nogap);
      int k = 0;
      int waits = 0;
      int cyc = 0;
      bit prev_stall = 1'b0;
      logic [33:0] prev_w = '0;
      logic [33:0] e;
      while (k < size + 14 && waits < 50) begin
         @(negedge clk);
         cfg_we = 1'b0;
         if (prev_stall)
            check(out_valid && {out_sop, out_eop, out_data} == prev_w, "R8",
                  "stalled word held", {29'd0, out_valid, out_sop, out_eop, out_data},
                  {30'd1, prev_w});
         out_ready = (mode == 0) || (cyc % (mode + 1) == 0);
         cyc++;
         prev_stall = 1'b0;
         if (!out_valid) begin
            if (k == 0) waits++;
            else check(1'b0, "R10", "bubble inside packet", 64'd0, 64'd1);
         end else if (out_ready) begin
            e = exp_word(k, size, run, ev, sp);
            check({out_sop, out_eop, out_data} == e, tag_of(k, size),
                  $sformatf("word %0d", k), {30'd0, out_sop, out_eop, out_data}, {30'd0, e});
            if (k == wr_at) begin
               cfg_we = 1'b1;
               cfg_wdata = wr_val;
            end
            k++;
         end else begin
            prev_stall = 1'b1;
            prev_w = {out_sop, out_eop, out_data};
         end
      end
      check(k == size + 14, "R5", "packet length", 64'(k), 64'(size + 14));
      if (need_nogap)
         check(waits == 0, "R10", "gap before next packet", 64'(waits), 64'd0);
   endtask

   task automatic idle_check(input int n, input bit poke_zero);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         out_ready = 1'b1;
         cfg_we = poke_zero && (i == 2);
         cfg_wdata = '0;
         check(out_valid == 1'b0, "R9", "no output after stop", 64'(out_valid), 64'd0);
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         out_ready = 1'b1;
         check(out_valid == 1'b0, "R1", "valid before any write", 64'(out_valid), 64'd0);
      end

      // main run: size 3, run 0x1234, two packets per spill
      start_gen(mkcfg(3, 16'h1234, 2));
      rx_pkt(3, 16'h1234, 0, 0, 0, -1, '0, 1'b0);
      rx_pkt(3, 16'h1234, 1, 0, 0, -1, '0, 1'b1);
      rx_pkt(3, 16'h1234, 2, 1, 1, -1, '0, 1'b1);
      // R10: reconfigure mid-packet to size 0, run 0xBEEF, frag 0 (acts as 1)
      rx_pkt(3, 16'h1234, 3, 1, 2, 5, mkcfg(0, 16'hBEEF, 0), 1'b1);
      rx_pkt(0, 16'hBEEF, 4, 2, 0, -1, '0, 1'b1);
      // R9: stop requested in the middle of a packet
      rx_pkt(0, 16'hBEEF, 5, 3, 1, 5, '0, 1'b1);
      idle_check(30, 1'b1);

      // R11: restart resets event and spill counters
      start_gen(mkcfg(2, 7, 3));
      rx_pkt(2, 7, 0, 0, 0, -1, '0, 1'b0);
      rx_pkt(2, 7, 1, 0, 2, 0, '0, 1'b1);
      idle_check(20, 1'b0);

      // sweep of payload sizes and stall patterns
      for (int s = 0; s < 6; s++) begin
         start_gen(mkcfg(s, 16'h0100 + s, 2));
         rx_pkt(s, 16'h0100 + s, 0, 0, s % 3, -1, '0, 1'b0);
         rx_pkt(s, 16'h0100 + s, 1, 0, (s + 1) % 3, -1, '0, 1'b1);
         rx_pkt(s, 16'h0100 + s, 2, 1, (s + 2) % 3, 0, '0, 1'b1);
         idle_check(8, 1'b0);
      end

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule